// File: doc/BRIEF.md
# Banked FIR Coefficient Address Generator

This block turns a tap index into an address for a 128-word coefficient store that feeds either one FIR filter or two interleaved FIR filters, A and B. The store is split into a lower and an upper coefficient bank. The split changes with the tap length and with the single/dual mode, so a complete second coefficient set can be held and brought into use in one step.

The bank in use comes from one of two sources: an external swap pin or a control-register bit. A source-select input picks between them. A change of the selected source is not applied at once. A four-state machine records it and commits it on the next sample strobe, so every tap of one output sample reads from the same bank. The states are `ST_LOW` (lower bank, no request), `ST_LOW_PEND` (lower bank, request for upper waiting), `ST_HIGH` (upper bank, no request) and `ST_HIGH_PEND` (upper bank, request for lower waiting). The transitions are named *arm*: a request differs from the bank in use and no strobe is present, so the machine enters the matching pending state. *Disarm*: the request returns to the bank in use before a strobe, so the machine goes back to the plain state. *Commit*: on a strobe, the machine enters `ST_HIGH` or `ST_LOW` according to the request at that moment. In the two configurations that cannot swap, the request is forced low.

Top module: `fir_coef_addr_gen`

## Requirements
- R1: After reset the lower bank is in use, even with the selected swap source high, until a sample strobe occurs.
- R2: With `dual_mode`=0 and `len_sel`=0 (one 128-tap filter), `coef_addr` equals `tap_idx`, and a swap request has no effect on the address.
- R3: With `dual_mode`=0, `len_sel`=1, 2 and 3 select 64, 32 and 16 taps (N). The lower bank is 0..N-1 and the upper bank is N..2N-1.
- R4: With `dual_mode`=1 and `len_sel`=0 (64 taps each), filter A (`filt_b`=0) uses 0..63 and filter B uses 64..127, and a swap request has no effect.
- R5: With `dual_mode`=1, `len_sel`=1 selects 32 taps and `len_sel`=2 selects 16 taps (N). The bases are A lower 0, A upper N, B lower 2N and B upper 3N.
- R6: With `dual_mode`=1 and `len_sel`=3 (8 taps each), the bases are A lower 0, B lower 8, A upper 16 and B upper 24.
- R7: With `swap_from_reg`=1 the bank request follows `swap_reg`; with `swap_from_reg`=0 it follows `swap_pin`. A high request selects the upper bank and a low request selects the lower bank.
- R8: A request sampled at the rising edge where `sample_stb`=1 sets the bank from the next cycle on. Between strobes the bank does not change, whatever the request does.
- R9: `tap_idx` bits at and above log2 of the per-filter tap count are ignored, and `coef_addr` never leaves the range that the configuration occupies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 0 = one filter, 1 = two interleaved filters |
| len_sel | input | 2 | Tap length code (0 = longest, then halves) |
| swap_from_reg | input | 1 | Swap source select: 1 = register bit, 0 = pin |
| swap_pin | input | 1 | External bank swap request |
| swap_reg | input | 1 | Register bank swap request |
| sample_stb | input | 1 | Sample-clock boundary strobe |
| filt_b | input | 1 | In dual mode, 1 addresses filter B |
| tap_idx | input | 7 | Tap index within the filter |
| coef_addr | output | 7 | Coefficient store address |

## Verification
The bench builds the block with its default 7-bit address, which is the 128-word store. All four length codes in both modes are therefore reachable, including the two configurations that cannot swap and the dual 8-tap layout, whose filter and bank fields trade places. With a 7-bit tap index, indices far beyond every shorter filter length can be driven, which is what the wrap check relies on. The request is raised and dropped between strobes to exercise the arm and disarm transitions before a commit.

// File: rtl/fir_bank_pkg.sv
`timescale 1ns/1ps
package fir_bank_pkg;

    typedef enum logic [1:0] {
        ST_LOW       = 2'b00,
        ST_LOW_PEND  = 2'b01,
        ST_HIGH      = 2'b10,
        ST_HIGH_PEND = 2'b11
    } bank_state_e;

    typedef enum logic [1:0] {
        LEN_FULL    = 2'd0,
        LEN_HALF    = 2'd1,
        LEN_QUARTER = 2'd2,
        LEN_EIGHTH  = 2'd3
    } len_code_e;

endpackage

// File: rtl/fir_swap_req.sv
`timescale 1ns/1ps
module fir_swap_req (
    input  logic       swap_from_reg,
    input  logic       swap_pin,
    input  logic       swap_reg,
    input  logic [1:0] len_sel,
    output logic       swap_ok,
    output logic       req_upper
);
    import fir_bank_pkg::*;

    logic raw_req;

    always_comb begin
        raw_req   = swap_from_reg ? swap_reg : swap_pin;
        swap_ok   = (len_code_e'(len_sel) != LEN_FULL);
        req_upper = raw_req & swap_ok;
    end

endmodule

// File: rtl/fir_bank_fsm.sv
`timescale 1ns/1ps
module fir_bank_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic req_upper,
    output logic bank_upper
);
    import fir_bank_pkg::*;

    bank_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOW;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOW: begin
                if (sample_stb)     nxt = req_upper ? ST_HIGH : ST_LOW;
                else if (req_upper) nxt = ST_LOW_PEND;
            end
            ST_LOW_PEND: begin
                if (sample_stb)     nxt = req_upper ? ST_HIGH : ST_LOW;
                else if (!req_upper) nxt = ST_LOW;
            end
            ST_HIGH: begin
                if (sample_stb)     nxt = req_upper ? ST_HIGH : ST_LOW;
                else if (!req_upper) nxt = ST_HIGH_PEND;
            end
            ST_HIGH_PEND: begin
                if (sample_stb)     nxt = req_upper ? ST_HIGH : ST_LOW;
                else if (req_upper) nxt = ST_HIGH;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_LOW, ST_LOW_PEND:   bank_upper = 1'b0;
            ST_HIGH, ST_HIGH_PEND: bank_upper = 1'b1;
        endcase
    end

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(bank_upper));

    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (bank_upper == $past(req_upper)));

endmodule

// File: rtl/fir_addr_map.sv
`timescale 1ns/1ps
module fir_addr_map #(
    parameter int ADDR_W = 7
) (
    input  logic              dual_mode,
    input  logic [1:0]        len_sel,
    input  logic              swap_ok,
    input  logic              bank_upper,
    input  logic              filt_b,
    input  logic [ADDR_W-1:0] tap_idx,
    output logic [ADDR_W-1:0] coef_addr
);
    import fir_bank_pkg::*;

    localparam int AW1 = ADDR_W + 1;
    localparam logic [AW1-1:0] FULL = AW1'(1) << ADDR_W;

    logic [2:0]     shamt;
    logic [AW1-1:0] n_words, n_twice, mask, offset, base, sum;
    logic           eighth;

    always_comb begin
        shamt   = {1'b0, len_sel} + {2'b00, dual_mode};
        n_words = FULL >> shamt;
        n_twice = n_words << 1;
        mask    = n_words - AW1'(1);
        offset  = {1'b0, tap_idx} & mask;
        eighth  = dual_mode && (len_code_e'(len_sel) == LEN_EIGHTH);
        base    = '0;
        if (!dual_mode) begin
            if (swap_ok && bank_upper) base = n_words;
        end else if (eighth) begin
            if (bank_upper) base = base + n_twice;
            if (filt_b)     base = base + n_words;
        end else if (swap_ok) begin
            if (filt_b)     base = base + n_twice;
            if (bank_upper) base = base + n_words;
        end else begin
            if (filt_b)     base = n_words;
        end
        sum       = base + offset;
        coef_addr = sum[ADDR_W-1:0];
    end

endmodule

// File: rtl/fir_coef_addr_gen.sv
`timescale 1ns/1ps
module fir_coef_addr_gen #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic [1:0]        len_sel,
    input  logic              swap_from_reg,
    input  logic              swap_pin,
    input  logic              swap_reg,
    input  logic              sample_stb,
    input  logic              filt_b,
    input  logic [ADDR_W-1:0] tap_idx,
    output logic [ADDR_W-1:0] coef_addr
);
    localparam int AW1 = ADDR_W + 1;
    localparam logic [AW1-1:0] FULL = AW1'(1) << ADDR_W;

    logic swap_ok, req_upper, bank_upper;

    fir_swap_req u_req (
        .swap_from_reg (swap_from_reg),
        .swap_pin      (swap_pin),
        .swap_reg      (swap_reg),
        .len_sel       (len_sel),
        .swap_ok       (swap_ok),
        .req_upper     (req_upper)
    );

    fir_bank_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .req_upper  (req_upper),
        .bank_upper (bank_upper)
    );

    fir_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .dual_mode  (dual_mode),
        .len_sel    (len_sel),
        .swap_ok    (swap_ok),
        .bank_upper (bank_upper),
        .filt_b     (filt_b),
        .tap_idx    (tap_idx),
        .coef_addr  (coef_addr)
    );

    logic [AW1-1:0] span;
    always_comb span = (len_sel == 2'd0) ? FULL : (FULL >> (len_sel - 2'd1));

    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, coef_addr} < span));

    p_filter_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && len_sel != 2'd3) |->
            (filt_b == ({1'b0, coef_addr} >= (span >> 1))));

    p_dual8_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && len_sel == 2'd3) |->
            (coef_addr[3] == filt_b && coef_addr[4] == bank_upper));

endmodule

// File: tb/sim_fir_coef_addr_gen.sv
`timescale 1ns/1ps
module sim_fir_coef_addr_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_mode = 1'b0;
    logic [1:0] len_sel = 2'd1;
    logic       swap_from_reg = 1'b0;
    logic       swap_pin = 1'b0;
    logic       swap_reg = 1'b0;
    logic       sample_stb = 1'b0;
    logic       filt_b = 1'b0;
    logic [6:0] tap_idx = '0;
    logic [6:0] coef_addr;

    int errors = 0;
    int checks = 0;
    bit mbank = 1'b0;

    always #2.5 clk = ~clk;

    fir_coef_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .len_sel(len_sel),
        .swap_from_reg(swap_from_reg), .swap_pin(swap_pin), .swap_reg(swap_reg),
        .sample_stb(sample_stb), .filt_b(filt_b), .tap_idx(tap_idx),
        .coef_addr(coef_addr)
    );

    function automatic int exp_addr(bit d, int l, bit bk, bit fb, int t);
        if (!d) begin
            case (l)
                0: return t % 128;
                1: return bk * 64 + t % 64;
                2: return bk * 32 + t % 32;
                default: return bk * 16 + t % 16;
            endcase
        end else begin
            case (l)
                0: return fb * 64 + t % 64;
                1: return fb * 64 + bk * 32 + t % 32;
                2: return fb * 32 + bk * 16 + t % 16;
                default: return bk * 16 + fb * 8 + t % 8;
            endcase
        end
    endfunction

    task automatic chk(string req, bit fb, int t, int expv);
        @(negedge clk);
        filt_b  = fb;
        tap_idx = 7'(t);
        #1;
        checks++;
        if (int'(coef_addr) != expv) begin
            errors++;
            $display("FAIL %s: tap=%0d fb=%0d got %0d expected %0d", req, t, fb, coef_addr, expv);
        end
    endtask

    task automatic chk_model(string req, bit fb, int t);
        chk(req, fb, t, exp_addr(dual_mode, int'(len_sel), mbank, fb, t));
    endtask

    task automatic cfg(bit d, int l);
        @(negedge clk);
        dual_mode = d;
        len_sel   = 2'(l);
    endtask

    task automatic strobe();
        @(negedge clk);
        sample_stb = 1'b1;
        @(posedge clk);
        mbank = (len_sel != 2'd0) && (swap_from_reg ? swap_reg : swap_pin);
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic t_reset();
        cfg(0, 1);
        swap_pin = 1'b1;
        chk("R1", 0, 5, 5);
        chk("R1", 0, 63, 63);
    endtask

    task automatic t_single_full();
        cfg(0, 0);
        swap_pin = 1'b1;
        strobe();
        chk("R2", 0, 100, 100);
        chk("R2", 0, 127, 127);
    endtask

    task automatic t_single_banks();
        for (int l = 1; l < 4; l++) begin
            cfg(0, l);
            swap_pin = 1'b0; strobe();
            chk("R3", 0, 3, 3);
            swap_pin = 1'b1; strobe();
            chk("R3", 0, 3, (128 >> l) + 3);
            chk_model("R3", 0, (128 >> l) - 1);
        end
    endtask

    task automatic t_dual_full();
        cfg(1, 0);
        swap_pin = 1'b1; strobe();
        chk("R4", 0, 10, 10);
        chk("R4", 1, 10, 74);
        chk("R4", 1, 63, 127);
    endtask

    task automatic t_dual_banks();
        for (int l = 1; l < 3; l++) begin
            cfg(1, l);
            for (int b = 0; b < 2; b++) begin
                swap_pin = b[0]; strobe();
                for (int f = 0; f < 2; f++)
                    chk("R5", f[0], 1, (f * 2 + b) * (64 >> l) + 1);
            end
        end
    endtask

    task automatic t_dual8();
        cfg(1, 3);
        swap_pin = 1'b0; strobe();
        chk("R6", 0, 2, 2);
        chk("R6", 1, 2, 10);
        swap_pin = 1'b1; strobe();
        chk("R6", 0, 2, 18);
        chk("R6", 1, 7, 31);
    endtask

    task automatic t_source();
        cfg(0, 2);
        swap_from_reg = 1'b1; swap_pin = 1'b1; swap_reg = 1'b0; strobe();
        chk("R7", 0, 4, 4);
        swap_reg = 1'b1; swap_pin = 1'b0; strobe();
        chk("R7", 0, 4, 36);
        swap_from_reg = 1'b0; strobe();
        chk("R7", 0, 4, 4);
    endtask

    task automatic t_timing();
        cfg(0, 2);
        swap_from_reg = 1'b0; swap_pin = 1'b0; strobe();
        @(negedge clk); swap_pin = 1'b1;
        chk("R8", 0, 6, 6);
        chk("R8", 0, 6, 6);
        @(negedge clk); swap_pin = 1'b0;
        strobe();
        chk("R8", 0, 6, 6);
        @(negedge clk); swap_pin = 1'b1;
        @(negedge clk); sample_stb = 1'b1;
        @(posedge clk); mbank = 1'b1;
        @(negedge clk); sample_stb = 1'b0; swap_pin = 1'b0;
        #1;
        checks++;
        if (coef_addr != 7'd38) begin
            errors++;
            $display("FAIL R8: got %0d expected 38 in cycle after strobe", coef_addr);
        end
        chk("R8", 0, 6, 38);
    endtask

    task automatic t_wrap();
        cfg(0, 3);
        swap_pin = 1'b1; strobe();
        chk("R9", 0, 127, 31);
        cfg(1, 3);
        swap_pin = 1'b0; strobe();
        chk("R9", 1, 122, 10);
        cfg(1, 1);
        chk("R9", 1, 127, 95);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_full();
        t_single_banks();
        t_dual_full();
        t_dual_banks();
        t_dual8();
        t_source();
        t_timing();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule